// File: doc/BRIEF.md
# Bypass Select and Load-Use Interlock

This block is the hazard control for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Every cycle it looks at the source register numbers of the instruction now in execute. It compares them with the destination numbers and write enables of the two older instructions, one in the memory stage and one in writeback. From that it picks where each ALU operand and the store data come from: the register file, the memory-stage result, or the writeback result. The choice of the younger producer wins, so a chain of dependent ALU instructions runs without losing a cycle.

Bypassing cannot help when a load sits in execute and the instruction in decode reads the loaded register, because the data does not exist yet. In that case the block freezes the program counter and the fetch/decode register for one cycle and squashes the enables of the instruction entering execute, so that a bubble goes down the pipe. After the bubble the loaded value is picked up from writeback. One case is exempt: a store that needs the loaded register only as the value to write. That store goes ahead without a stall. The value is then passed from writeback into the store's data path while the store is in the memory stage, and the block drives a separate select for that.

Registers are read only in decode and written only in writeback, so anti- and output-dependences cannot occur and are not checked. The block is purely combinational. Clock and reset exist only to time its bound assertions.

Top module: `pipeHazardCtl`

## Requirements
- R1: When execute reads rs1 (`exUseRs1`=1) and the memory-stage producer has `memRegWe`=1 and a nonzero `memRd` equal to `exRs1`, `fwdA` is 2'b10 (memory-stage result).
- R2: When only the writeback producer (`wbRegWe`=1, nonzero `wbRd` equal to the source) matches, the select is 2'b01 (writeback result).
- R3: When both producers match the same source, the memory-stage producer wins and the select is 2'b10.
- R4: Register 0, a producer with its write enable low, or a source that the instruction does not read, gives select 2'b00 (register file).
- R5: `fwdB` follows the rules of R1 to R4 using `exRs2` gated by `exUseRs2`. `fwdStore` follows the same rules using `exRs2` gated by `exIsStore`. The value 2'b11 never appears.
- R6: A load in execute (`exMemRe`=1, `exRegWe`=1, nonzero `exRd`) whose destination equals a source that decode reads raises both `pcHold` and `ifIdHold` in that cycle.
- R7: While the stall is raised, `idExRegWe`, `idExMemWe` and `idExMemRe` are 0. Otherwise they equal `idRegWe`, `idMemWe` and `idMemRe`.
- R8: No stall when the execute instruction is not a load, when its write enable is low, or when its destination is register 0.
- R9: A store in decode (`idIsStore`=1) whose only match with the loaded register is its data source rs2 does not stall. A match on its address source rs1 does stall.
- R10: `memStoreFwd` is 1 exactly when the memory stage holds a store (`memIsStore`=1) whose `memRs2` equals a nonzero `wbRd` with `wbRegWe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bound assertions |
| rstN | input | 1 | Active-low reset for the bound assertions |
| idRs1 | input | 5 | Decode-stage first source register |
| idRs2 | input | 5 | Decode-stage second source register |
| idUseRs1 | input | 1 | Decode instruction reads rs1 |
| idUseRs2 | input | 1 | Decode instruction reads rs2 |
| idIsStore | input | 1 | Decode instruction is a store |
| idRegWe | input | 1 | Decoded register write enable |
| idMemWe | input | 1 | Decoded memory write enable |
| idMemRe | input | 1 | Decoded memory read enable |
| exRs1 | input | 5 | Execute-stage first source |
| exRs2 | input | 5 | Execute-stage second source |
| exUseRs1 | input | 1 | ALU reads rs1 |
| exUseRs2 | input | 1 | ALU reads rs2 as an operand |
| exIsStore | input | 1 | Execute instruction is a store |
| exRd | input | 5 | Execute-stage destination |
| exRegWe | input | 1 | Execute-stage register write enable |
| exMemRe | input | 1 | Execute instruction is a load |
| memRd | input | 5 | Memory-stage destination |
| memRegWe | input | 1 | Memory-stage register write enable |
| memRs2 | input | 5 | Memory-stage store data source |
| memIsStore | input | 1 | Memory-stage instruction is a store |
| wbRd | input | 5 | Writeback destination |
| wbRegWe | input | 1 | Writeback register write enable |
| fwdA | output | 2 | ALU operand A select |
| fwdB | output | 2 | ALU operand B select |
| fwdStore | output | 2 | Execute-stage store data select |
| memStoreFwd | output | 1 | Memory-stage store data takes writeback value |
| pcHold | output | 1 | Freeze program counter |
| ifIdHold | output | 1 | Freeze fetch/decode register |
| idExRegWe | output | 1 | Register write enable into execute |
| idExMemWe | output | 1 | Memory write enable into execute |
| idExMemRe | output | 1 | Memory read enable into execute |

## Verification
Single-producer patterns, one in the memory stage and one in writeback, show that each bypass path is picked for the right stage. The same register in both stages separates correct age priority from a reversed one. Patterns with register 0, a cleared write enable, or a cleared use flag separate real dependences from false matches on the number alone. For the interlock, an ALU producer, a load with a decode reader, and a store whose data or address depends on the load separate a correct stall from stalling too often or too rarely. The memory-stage store select is tried with and without a writeback match.

// File: rtl/hazardPkg.sv
package hazardPkg;
  typedef enum logic [1:0] {
    SEL_REGFILE = 2'b00,
    SEL_WB      = 2'b01,
    SEL_MEM     = 2'b10
  } fwdSel_e;

  typedef struct packed {
    logic holdFetch;
    logic squashIdEx;
  } stallStrobe_t;
endpackage

// File: rtl/interlockCtl.sv
module interlockCtl
  import hazardPkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] idRs1,
  input  logic [ADDR_W-1:0] idRs2,
  input  logic              idUseRs1,
  input  logic              idUseRs2,
  input  logic              idIsStore,
  input  logic [ADDR_W-1:0] exRd,
  input  logic              exRegWe,
  input  logic              exMemRe,
  output stallStrobe_t      strobe
);
  localparam logic [ADDR_W-1:0] ZERO_REG = '0;

  logic loadLive;
  logic addrHit;
  logic dataHit;
  logic needStall;

  // a live load: reads memory, writes a real register
  assign loadLive = exMemRe && exRegWe && (exRd != ZERO_REG);
  assign addrHit  = idUseRs1 && (idRs1 == exRd);
  // a store's rs2 is its data; it can be bypassed later in MEM
  assign dataHit  = idUseRs2 && (idRs2 == exRd) && !idIsStore;

  assign needStall = loadLive && (addrHit || dataHit);

  always_comb begin
    strobe.holdFetch  = needStall;
    strobe.squashIdEx = needStall;
  end
endmodule

// File: rtl/bypassPath.sv
module bypassPath
  import hazardPkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] exRs1,
  input  logic [ADDR_W-1:0] exRs2,
  input  logic              exUseRs1,
  input  logic              exUseRs2,
  input  logic              exIsStore,
  input  logic [ADDR_W-1:0] memRd,
  input  logic              memRegWe,
  input  logic [ADDR_W-1:0] memRs2,
  input  logic              memIsStore,
  input  logic [ADDR_W-1:0] wbRd,
  input  logic              wbRegWe,
  input  logic              idRegWe,
  input  logic              idMemWe,
  input  logic              idMemRe,
  input  stallStrobe_t      strobe,
  output fwdSel_e           selA,
  output fwdSel_e           selB,
  output fwdSel_e           selStore,
  output logic              memStoreFwd,
  output logic              idExRegWe,
  output logic              idExMemWe,
  output logic              idExMemRe
);
  localparam int NUM_CONSUMERS = 3;
  localparam logic [ADDR_W-1:0] ZERO_REG = '0;

  logic              memLive;
  logic              wbLive;
  logic [ADDR_W-1:0] srcAddr [NUM_CONSUMERS];
  logic              srcUse  [NUM_CONSUMERS];
  fwdSel_e           selOut  [NUM_CONSUMERS];

  assign memLive = memRegWe && (memRd != ZERO_REG);
  assign wbLive  = wbRegWe && (wbRd != ZERO_REG);

  assign srcAddr[0] = exRs1;
  assign srcUse[0]  = exUseRs1;
  assign srcAddr[1] = exRs2;
  assign srcUse[1]  = exUseRs2;
  assign srcAddr[2] = exRs2;
  assign srcUse[2]  = exIsStore;

  for (genvar g = 0; g < NUM_CONSUMERS; g++) begin : gConsumer
    always_comb begin
      // younger producer checked first
      if (srcUse[g] && memLive && (memRd == srcAddr[g])) begin
        selOut[g] = SEL_MEM;
      end else if (srcUse[g] && wbLive && (wbRd == srcAddr[g])) begin
        selOut[g] = SEL_WB;
      end else begin
        selOut[g] = SEL_REGFILE;
      end
    end
  end

  assign selA     = selOut[0];
  assign selB     = selOut[1];
  assign selStore = selOut[2];

  // load data reaching a store that already sits in MEM
  assign memStoreFwd = memIsStore && wbLive && (wbRd == memRs2);

  // bubble: strip every side-effect enable
  assign idExRegWe = idRegWe && !strobe.squashIdEx;
  assign idExMemWe = idMemWe && !strobe.squashIdEx;
  assign idExMemRe = idMemRe && !strobe.squashIdEx;
endmodule

// File: rtl/pipeHazardCtl.sv
module pipeHazardCtl
  import hazardPkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] idRs1,
  input  logic [ADDR_W-1:0] idRs2,
  input  logic              idUseRs1,
  input  logic              idUseRs2,
  input  logic              idIsStore,
  input  logic              idRegWe,
  input  logic              idMemWe,
  input  logic              idMemRe,
  input  logic [ADDR_W-1:0] exRs1,
  input  logic [ADDR_W-1:0] exRs2,
  input  logic              exUseRs1,
  input  logic              exUseRs2,
  input  logic              exIsStore,
  input  logic [ADDR_W-1:0] exRd,
  input  logic              exRegWe,
  input  logic              exMemRe,
  input  logic [ADDR_W-1:0] memRd,
  input  logic              memRegWe,
  input  logic [ADDR_W-1:0] memRs2,
  input  logic              memIsStore,
  input  logic [ADDR_W-1:0] wbRd,
  input  logic              wbRegWe,
  output logic [1:0]        fwdA,
  output logic [1:0]        fwdB,
  output logic [1:0]        fwdStore,
  output logic              memStoreFwd,
  output logic              pcHold,
  output logic              ifIdHold,
  output logic              idExRegWe,
  output logic              idExMemWe,
  output logic              idExMemRe
);
  stallStrobe_t strobe;
  fwdSel_e      selA;
  fwdSel_e      selB;
  fwdSel_e      selStore;

  interlockCtl #(.ADDR_W(ADDR_W)) uCtl (
    .idRs1     (idRs1),
    .idRs2     (idRs2),
    .idUseRs1  (idUseRs1),
    .idUseRs2  (idUseRs2),
    .idIsStore (idIsStore),
    .exRd      (exRd),
    .exRegWe   (exRegWe),
    .exMemRe   (exMemRe),
    .strobe    (strobe)
  );

  bypassPath #(.ADDR_W(ADDR_W)) uPath (
    .exRs1       (exRs1),
    .exRs2       (exRs2),
    .exUseRs1    (exUseRs1),
    .exUseRs2    (exUseRs2),
    .exIsStore   (exIsStore),
    .memRd       (memRd),
    .memRegWe    (memRegWe),
    .memRs2      (memRs2),
    .memIsStore  (memIsStore),
    .wbRd        (wbRd),
    .wbRegWe     (wbRegWe),
    .idRegWe     (idRegWe),
    .idMemWe     (idMemWe),
    .idMemRe     (idMemRe),
    .strobe      (strobe),
    .selA        (selA),
    .selB        (selB),
    .selStore    (selStore),
    .memStoreFwd (memStoreFwd),
    .idExRegWe   (idExRegWe),
    .idExMemWe   (idExMemWe),
    .idExMemRe   (idExMemRe)
  );

  assign fwdA     = selA;
  assign fwdB     = selB;
  assign fwdStore = selStore;
  assign pcHold   = strobe.holdFetch;
  assign ifIdHold = strobe.holdFetch;
endmodule

// File: rtl/pipeHazardChecker.sv
module pipeHazardChecker #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] exRs1,
  input logic              exUseRs1,
  input logic              exMemRe,
  input logic [ADDR_W-1:0] memRd,
  input logic              memRegWe,
  input logic              memIsStore,
  input logic [1:0]        fwdA,
  input logic [1:0]        fwdB,
  input logic [1:0]        fwdStore,
  input logic              memStoreFwd,
  input logic              pcHold,
  input logic              ifIdHold,
  input logic              idExRegWe,
  input logic              idExMemWe,
  input logic              idExMemRe
);
  assert_young_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fwdA == 2'b01) |-> !(exUseRs1 && memRegWe && (memRd == exRs1) && (memRd != '0)));

  assert_zero_reg_R4: assert property (@(posedge clk) disable iff (!rstN)
    (exRs1 == '0) |-> (fwdA == 2'b00));

  assert_legal_sel_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fwdA != 2'b11) && (fwdB != 2'b11) && (fwdStore != 2'b11));

  assert_hold_pair_R6: assert property (@(posedge clk) disable iff (!rstN)
    pcHold == ifIdHold);

  assert_bubble_R7: assert property (@(posedge clk) disable iff (!rstN)
    pcHold |-> !(idExRegWe || idExMemWe || idExMemRe));

  assert_alu_nostall_R8: assert property (@(posedge clk) disable iff (!rstN)
    !exMemRe |-> !pcHold);

  assert_mem_store_R10: assert property (@(posedge clk) disable iff (!rstN)
    memStoreFwd |-> memIsStore);
endmodule

bind pipeHazardCtl pipeHazardChecker #(.ADDR_W(ADDR_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .exRs1       (exRs1),
  .exUseRs1    (exUseRs1),
  .exMemRe     (exMemRe),
  .memRd       (memRd),
  .memRegWe    (memRegWe),
  .memIsStore  (memIsStore),
  .fwdA        (fwdA),
  .fwdB        (fwdB),
  .fwdStore    (fwdStore),
  .memStoreFwd (memStoreFwd),
  .pcHold      (pcHold),
  .ifIdHold    (ifIdHold),
  .idExRegWe   (idExRegWe),
  .idExMemWe   (idExMemWe),
  .idExMemRe   (idExMemRe)
);

// File: tb/tb_pipeHazardCtl.sv
module tb_pipeHazardCtl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] idRs1, idRs2, exRs1, exRs2, exRd, memRd, memRs2, wbRd;
  logic idUseRs1, idUseRs2, idIsStore, idRegWe, idMemWe, idMemRe;
  logic exUseRs1, exUseRs2, exIsStore, exRegWe, exMemRe;
  logic memRegWe, memIsStore, wbRegWe;
  logic [1:0] fwdA, fwdB, fwdStore;
  logic memStoreFwd, pcHold, ifIdHold, idExRegWe, idExMemWe, idExMemRe;

  int vecCount = 0;
  int errCount = 0;

  always #4 clk = ~clk;

  pipeHazardCtl dut (
    .clk(clk), .rstN(rstN),
    .idRs1(idRs1), .idRs2(idRs2), .idUseRs1(idUseRs1), .idUseRs2(idUseRs2),
    .idIsStore(idIsStore), .idRegWe(idRegWe), .idMemWe(idMemWe), .idMemRe(idMemRe),
    .exRs1(exRs1), .exRs2(exRs2), .exUseRs1(exUseRs1), .exUseRs2(exUseRs2),
    .exIsStore(exIsStore), .exRd(exRd), .exRegWe(exRegWe), .exMemRe(exMemRe),
    .memRd(memRd), .memRegWe(memRegWe), .memRs2(memRs2), .memIsStore(memIsStore),
    .wbRd(wbRd), .wbRegWe(wbRegWe),
    .fwdA(fwdA), .fwdB(fwdB), .fwdStore(fwdStore), .memStoreFwd(memStoreFwd),
    .pcHold(pcHold), .ifIdHold(ifIdHold),
    .idExRegWe(idExRegWe), .idExMemWe(idExMemWe), .idExMemRe(idExMemRe)
  );

  task automatic chk(input string req, input int act, input int exp);
    vecCount++;
    if (act != exp) begin
      errCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic quiet();
    @(negedge clk);
    idRs1 = 0; idRs2 = 0; idUseRs1 = 0; idUseRs2 = 0; idIsStore = 0;
    idRegWe = 0; idMemWe = 0; idMemRe = 0;
    exRs1 = 0; exRs2 = 0; exUseRs1 = 0; exUseRs2 = 0; exIsStore = 0;
    exRd = 0; exRegWe = 0; exMemRe = 0;
    memRd = 0; memRegWe = 0; memRs2 = 0; memIsStore = 0;
    wbRd = 0; wbRegWe = 0;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic tIdle();
    quiet(); settle();
    chk("R4 idle fwdA", fwdA, 0);
    chk("R4 idle fwdB", fwdB, 0);
    chk("R8 idle stall", pcHold, 0);
  endtask

  task automatic tMemPath();
    quiet();
    exRs1 = 7; exUseRs1 = 1; memRd = 7; memRegWe = 1; settle();
    chk("R1 fwdA mem", fwdA, 2);
    chk("R5 fwdB untouched", fwdB, 0);
  endtask

  task automatic tWbPath();
    quiet();
    exRs1 = 9; exUseRs1 = 1; wbRd = 9; wbRegWe = 1; memRd = 3; memRegWe = 1; settle();
    chk("R2 fwdA wb", fwdA, 1);
  endtask

  task automatic tPriority();
    quiet();
    exRs1 = 12; exUseRs1 = 1; memRd = 12; memRegWe = 1; wbRd = 12; wbRegWe = 1; settle();
    chk("R3 both match", fwdA, 2);
    memRegWe = 0; settle();
    chk("R4 mem we low falls to wb", fwdA, 1);
  endtask

  task automatic tZeroReg();
    quiet();
    exRs1 = 0; exUseRs1 = 1; memRd = 0; memRegWe = 1; wbRd = 0; wbRegWe = 1; settle();
    chk("R4 reg zero", fwdA, 0);
    exRs1 = 5; memRd = 5; memRegWe = 0; wbRd = 5; wbRegWe = 0; settle();
    chk("R4 we low", fwdA, 0);
    memRegWe = 1; exUseRs1 = 0; settle();
    chk("R4 unread source", fwdA, 0);
  endtask

  task automatic tOperandB();
    quiet();
    exRs2 = 4; exUseRs2 = 1; wbRd = 4; wbRegWe = 1; settle();
    chk("R5 fwdB wb", fwdB, 1);
    chk("R5 fwdStore off", fwdStore, 0);
    exUseRs2 = 0; exIsStore = 1; memRd = 4; memRegWe = 1; settle();
    chk("R5 fwdStore mem", fwdStore, 2);
    chk("R5 fwdB off", fwdB, 0);
  endtask

  task automatic tLoadUse();
    quiet();
    idRegWe = 1; idMemWe = 1; idMemRe = 1;
    exRd = 6; exRegWe = 1; exMemRe = 1;
    idRs1 = 6; idUseRs1 = 1; settle();
    chk("R6 pcHold", pcHold, 1);
    chk("R6 ifIdHold", ifIdHold, 1);
    chk("R7 regWe squashed", idExRegWe, 0);
    chk("R7 memWe squashed", idExMemWe, 0);
    chk("R7 memRe squashed", idExMemRe, 0);
    idRs1 = 1; idRs2 = 6; idUseRs2 = 1; settle();
    chk("R6 rs2 reader stalls", pcHold, 1);
    idUseRs2 = 0; settle();
    chk("R6 unread rs2 no stall", pcHold, 0);
    chk("R7 regWe passes", idExRegWe, 1);
    chk("R7 memWe passes", idExMemWe, 1);
    chk("R7 memRe passes", idExMemRe, 1);
  endtask

  task automatic tNoStallCases();
    quiet();
    idRs1 = 8; idUseRs1 = 1; exRd = 8; exRegWe = 1; exMemRe = 0; settle();
    chk("R8 alu producer", pcHold, 0);
    exMemRe = 1; exRegWe = 0; settle();
    chk("R8 load we low", pcHold, 0);
    exRegWe = 1; exRd = 0; idRs1 = 0; settle();
    chk("R8 load to reg zero", pcHold, 0);
  endtask

  task automatic tStoreAfterLoad();
    quiet();
    exRd = 10; exRegWe = 1; exMemRe = 1;
    idIsStore = 1; idUseRs1 = 1; idUseRs2 = 1; idRs1 = 2; idRs2 = 10; settle();
    chk("R9 store data no stall", pcHold, 0);
    idRs1 = 10; settle();
    chk("R9 store address stalls", pcHold, 1);
  endtask

  task automatic tMemStore();
    quiet();
    memIsStore = 1; memRs2 = 11; wbRd = 11; wbRegWe = 1; settle();
    chk("R10 mem store fwd", memStoreFwd, 1);
    wbRegWe = 0; settle();
    chk("R10 wb we low", memStoreFwd, 0);
    wbRegWe = 1; memIsStore = 0; settle();
    chk("R10 not a store", memStoreFwd, 0);
    memIsStore = 1; memRs2 = 0; wbRd = 0; settle();
    chk("R10 reg zero", memStoreFwd, 0);
  endtask

  initial begin
    #(8 * 100000);
    errCount++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    quiet();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tIdle();
    tMemPath();
    tWbPath();
    tPriority();
    tZeroReg();
    tOperandB();
    tLoadUse();
    tNoStallCases();
    tStoreAfterLoad();
    tMemStore();
    quiet();
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end
endmodule